// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block is an 8-bit bidirectional I/O port driven by a small processor over a simple register bus. Each pin has a direction bit, a bit in the output latch, and a synchronized input sample. Software writes a direction register and an output latch, and it can read back either the latch or the live pin levels. Because these two reads are separate, a read-modify-write sequence works on the stored output values and is not upset by the external load on a pin.

Two peripherals can take the pins over. Three PWM outputs can each claim one of the top three pins; the pin is then driven with the PWM value. A request input can hand the whole port to an external parallel slave interface, which then supplies the output enables and output data for every pin. While the PWM runs in a multi-output (dual or quad) mode, the slave request is ignored. Each pin follows this priority: PWM takeover first, then slave ownership, then the normal direction and latch control.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the output latch reads 0x00 and every pin output enable (pinOe) is 0.
- R2: With the slave path and PWM inactive, a direction bit of 0 sets that pin's output enable to 1 and drives the latch bit onto pinOut; a direction bit of 1 sets the output enable to 0.
- R3: A read at address 1 returns the stored output latch, not the pin level, so software can read the latch, modify it and write it back.
- R4: A read at address 0 returns the pin levels through a two-stage synchronizer: a change on pinIn ahead of a clock edge shows in the read after the second such edge and not after the first.
- R5: A write strobe at address 0 or address 1 loads regWdata into the output latch, a write at address 2 loads the direction register, and a write at address 3 changes no register; a read at address 3 returns 0x00.
- R6: When pwmSel bit k is 1 (k = 0..2), pin 5+k is driven (output enable 1) with pwmData bit k, whatever the slave request, the direction and the latch.
- R7: When slaveReq is 1 and pwmMulti is 0, every pin that no PWM claims takes its output enable from slaveOe and its output value from slaveData.
- R8: When pwmMulti is 1, slaveReq has no effect and the pins not claimed by PWM follow the direction and latch registers.
- R9: Writing 0xCF to the direction register makes pins 3:0 and 7:6 inputs and pins 5:4 outputs, so pinOe reads 0x30.
- R10: Register contents survive slave ownership: after slaveReq falls, the pins follow the direction and latch values written before and during slave ownership.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address: 0 pins, 1 latch, 2 direction |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Combinational read data |
| pinIn | input | 8 | Sampled pad levels |
| pinOut | output | 8 | Pad output values |
| pinOe | output | 8 | Pad output enables, 1 drives the pin |
| pwmSel | input | 3 | PWM takeover for pins 7:5 (bit 0 is pin 5) |
| pwmData | input | 3 | PWM output values for pins 7:5 |
| pwmMulti | input | 1 | PWM in dual or quad output mode |
| slaveReq | input | 1 | Request to hand the port to the slave interface |
| slaveOe | input | 8 | Slave-interface output enables |
| slaveData | input | 8 | Slave-interface output values |

## Verification
The overlaps that matter are PWM takeover arriving while the slave interface owns the port, and the multi-output PWM mode arriving together with the slave request. The bench raises slaveReq and a PWM select in the same cycle and checks that the claimed pins carry PWM values while the rest carry slave values. It then raises pwmMulti with slaveReq still high and checks that the unclaimed pins switch back to the direction and latch contents. A register write made while the slave owns the port is checked again after ownership ends.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam logic [1:0] ADDR_PINS = 2'd0;
  localparam logic [1:0] ADDR_LAT  = 2'd1;
  localparam logic [1:0] ADDR_DIR  = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic latWr;
    logic dirWr;
    logic rdPins;
    logic rdLat;
    logic rdDir;
    logic slaveOwn;
  } portStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [1:0]  regAddr,
  input  logic        regWr,
  input  logic        pwmMulti,
  input  logic        slaveReq,
  output portStrobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.rdPins   = (regAddr == ADDR_PINS);
    strobe.rdLat    = (regAddr == ADDR_LAT);
    strobe.rdDir    = (regAddr == ADDR_DIR);
    // both the pin address and the latch address write the latch
    strobe.latWr    = regWr && (regAddr == ADDR_PINS || regAddr == ADDR_LAT);
    strobe.dirWr    = regWr && (regAddr == ADDR_DIR);
    // multi-output PWM blocks slave ownership
    strobe.slaveOwn = slaveReq && !pwmMulti;
  end

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int PWM_PINS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         strobe,
  input  logic [WIDTH-1:0]    wdata,
  output logic [WIDTH-1:0]    rdata,
  input  logic [WIDTH-1:0]    pinIn,
  output logic [WIDTH-1:0]    pinOut,
  output logic [WIDTH-1:0]    pinOe,
  input  logic [PWM_PINS-1:0] pwmSel,
  input  logic [PWM_PINS-1:0] pwmData,
  input  logic [WIDTH-1:0]    slaveOe,
  input  logic [WIDTH-1:0]    slaveData
);

  localparam int PWM_BASE = WIDTH - PWM_PINS;
  localparam int LAST     = SYNC_STAGES - 1;

  logic [WIDTH-1:0] latReg;
  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latReg <= '0;
      dirReg <= '1;
    end else begin
      if (strobe.latWr) latReg <= wdata;
      if (strobe.dirWr) dirReg <= wdata;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncStage[s] <= '0;
      else if (s == 0) syncStage[s] <= pinIn;
      else             syncStage[s] <= syncStage[(s == 0) ? 0 : s - 1];
    end
  end

  always_comb begin
    rdata = '0;
    if (strobe.rdPins)     rdata = syncStage[LAST];
    else if (strobe.rdLat) rdata = latReg;
    else if (strobe.rdDir) rdata = dirReg;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i >= PWM_BASE) begin : g_pwm
      localparam int K = i - PWM_BASE;
      always_comb begin
        if (pwmSel[K]) begin
          pinOe[i]  = 1'b1;
          pinOut[i] = pwmData[K];
        end else if (strobe.slaveOwn) begin
          pinOe[i]  = slaveOe[i];
          pinOut[i] = slaveData[i];
        end else begin
          pinOe[i]  = !dirReg[i];
          pinOut[i] = latReg[i];
        end
      end
    end else begin : g_plain
      always_comb begin
        if (strobe.slaveOwn) begin
          pinOe[i]  = slaveOe[i];
          pinOut[i] = slaveData[i];
        end else begin
          pinOe[i]  = !dirReg[i];
          pinOut[i] = latReg[i];
        end
      end
    end
  end

  AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latWr |=> latReg == $past(wdata)); // R5
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latWr |=> $stable(latReg)); // R5
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dirWr |=> $stable(dirReg)); // R5
  AST_SYNC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> syncStage[LAST] == $past(syncStage[0], LAST)); // R4
  AST_LOW_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.slaveOwn |-> pinOe[PWM_BASE-1:0] == ~dirReg[PWM_BASE-1:0]); // R8

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int PWM_PINS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          regAddr,
  input  logic                regWr,
  input  logic [WIDTH-1:0]    regWdata,
  output logic [WIDTH-1:0]    regRdata,
  input  logic [WIDTH-1:0]    pinIn,
  output logic [WIDTH-1:0]    pinOut,
  output logic [WIDTH-1:0]    pinOe,
  input  logic [PWM_PINS-1:0] pwmSel,
  input  logic [PWM_PINS-1:0] pwmData,
  input  logic                pwmMulti,
  input  logic                slaveReq,
  input  logic [WIDTH-1:0]    slaveOe,
  input  logic [WIDTH-1:0]    slaveData
);

  localparam int PWM_BASE = WIDTH - PWM_PINS;

  portStrobe_t strobe;

  gpio_port_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWr   (regWr),
    .pwmMulti(pwmMulti),
    .slaveReq(slaveReq),
    .strobe  (strobe)
  );

  gpio_port_dp #(
    .WIDTH      (WIDTH),
    .PWM_PINS   (PWM_PINS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (regWdata),
    .rdata    (regRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .pwmSel   (pwmSel),
    .pwmData  (pwmData),
    .slaveOe  (slaveOe),
    .slaveData(slaveData)
  );

  AST_PWM_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (pinOe[WIDTH-1:PWM_BASE] & pwmSel) == pwmSel); // R6
  AST_PWM_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut[WIDTH-1:PWM_BASE] & pwmSel) == (pwmData & pwmSel)); // R6
  AST_SLAVE_OWNS: assert property (@(posedge clk) disable iff (!rstN)
    (slaveReq && !pwmMulti) |-> pinOe[PWM_BASE-1:0] == slaveOe[PWM_BASE-1:0]); // R7

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [7:0] pinIn = 8'h00;
  logic [7:0] pinOut;
  logic [7:0] pinOe;
  logic [2:0] pwmSel = 3'b000;
  logic [2:0] pwmData = 3'b000;
  logic       pwmMulti = 1'b0;
  logic       slaveReq = 1'b0;
  logic [7:0] slaveOe = 8'h00;
  logic [7:0] slaveData = 8'h00;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .pwmSel(pwmSel), .pwmData(pwmData),
    .pwmMulti(pwmMulti), .slaveReq(slaveReq), .slaveOe(slaveOe),
    .slaveData(slaveData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWr = 1'b1; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic testReset();
    logic [7:0] v;
    readReg(2'd2, v); check("R1 dir", v, 8'hFF);
    readReg(2'd1, v); check("R1 latch", v, 8'h00);
    check("R1 oe", pinOe, 8'h00);
  endtask

  task automatic testDirection();
    writeReg(2'd1, 8'hA5);
    writeReg(2'd2, 8'h0F);
    #1;
    check("R2 oe", pinOe, 8'hF0);
    check("R2 out", pinOut & pinOe, 8'hA0);
    writeReg(2'd2, 8'hCF);
    #1;
    check("R9 oe", pinOe, 8'h30);
  endtask

  task automatic testLatchRmw();
    logic [7:0] v;
    writeReg(2'd2, 8'h00);
    writeReg(2'd1, 8'h3C);
    pinIn = 8'hC3;
    repeat (3) @(negedge clk);
    readReg(2'd1, v); check("R3 latch", v, 8'h3C);
    readReg(2'd0, v); check("R3 pins", v, 8'hC3);
    readReg(2'd1, v);
    writeReg(2'd0, v | 8'h01);
    readReg(2'd1, v); check("R3 rmw", v, 8'h3D);
    check("R3 pinOut", pinOut, 8'h3D);
  endtask

  task automatic testSync();
    logic [7:0] v;
    @(negedge clk);
    regAddr = 2'd0;
    pinIn = 8'h5A;
    @(negedge clk);
    readReg(2'd0, v); check("R4 one edge", v, 8'hC3);
    @(negedge clk);
    readReg(2'd0, v); check("R4 two edges", v, 8'h5A);
  endtask

  task automatic testAddr3();
    logic [7:0] v;
    writeReg(2'd3, 8'h77);
    readReg(2'd3, v); check("R5 addr3 read", v, 8'h00);
    readReg(2'd1, v); check("R5 latch kept", v, 8'h3D);
    readReg(2'd2, v); check("R5 dir kept", v, 8'h00);
    writeReg(2'd1, 8'h81);
    readReg(2'd1, v); check("R5 latch write", v, 8'h81);
  endtask

  task automatic testPwm();
    writeReg(2'd2, 8'hFF);
    @(negedge clk);
    pwmSel = 3'b101; pwmData = 3'b001;
    #1;
    check("R6 oe", pinOe, 8'hA0);
    check("R6 out", pinOut & 8'hE0, 8'h20);
    pwmSel = 3'b000; pwmData = 3'b000;
  endtask

  task automatic testSlaveAndOverlap();
    logic [7:0] v;
    writeReg(2'd2, 8'hF0);
    writeReg(2'd1, 8'h0A);
    @(negedge clk);
    slaveOe = 8'h3C; slaveData = 8'h55;
    slaveReq = 1'b1; pwmSel = 3'b100; pwmData = 3'b100;
    #1;
    check("R7 oe", pinOe, 8'hBC);
    check("R7 out", pinOut, 8'hD5);
    pwmMulti = 1'b1;
    #1;
    check("R8 oe", pinOe, 8'h8F);
    check("R8 out", pinOut, 8'h8A);
    pwmMulti = 1'b0; pwmSel = 3'b000; pwmData = 3'b000;
    writeReg(2'd1, 8'h06);
    writeReg(2'd2, 8'hF9);
    #1;
    check("R7 during write", pinOe, 8'h3C);
    @(negedge clk);
    slaveReq = 1'b0;
    #1;
    check("R10 oe", pinOe, 8'h06);
    check("R10 out", pinOut, 8'h06);
    readReg(2'd1, v); check("R10 latch", v, 8'h06);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirection();
    testLatchRmw();
    testSync();
    testAddr3();
    testPwm();
    testSlaveAndOverlap();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule